// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable, device-side model of a small serial EEPROM with a 1 Kbit array. A host reaches it through a chip select, a shift clock and a serial data input. Replies come back on a serial output with a separate drive enable, which stands for the tri-state pin. An organization input picks between 64 words of 16 bits and 128 words of 8 bits. The serial pins are sampled with the system clock, so the shift clock must be much slower than the system clock.

Each transaction opens with a start bit, a two-bit opcode and an address. Seven commands are decoded: read, write, erase, erase all, write all, enable programming and disable programming. Programming is refused until the enable command has been given. Every accepted programming command runs a self-timed cycle of `PROG_CYCLES` system clocks. The host can poll that cycle by dropping chip select for at least `MIN_CS_LOW` clocks and then raising it again. While a cycle runs, no new start bit is accepted.

Top module: `eeprom3w`

## Requirements
- R1: A command begins with the first shift-clock rise that samples data in at 1 while chip select is high; zeros before it are skipped. The next two bits are the opcode (first bit is the MSB). After them come 7 address bits when org is 0, or 6 when org is 1, MSB first.
- R2: Read (opcode 10) drives dout_en high with dout 0 on the rise that takes the last address bit. Each later rise then shows one data bit, MSB first. The rise after the last data bit releases dout_en.
- R3: With org 1 the word is 16 bits and the address selects one of 64 words. With org 0 the word is 8 bits: address bits 6..1 select the 16-bit word, and address bit 0 selects its upper byte (1) or lower byte (0).
- R4: After reset, programming is disabled, every array bit is 1 and dout_en is low.
- R5: Opcode 00 with the top two address bits 11 enables programming. Opcode 00 with 00 disables it. The other address bits are don't-care but must still be clocked in. Read works in either state.
- R6: Write (opcode 01) stores the data word that follows the address, MSB first, once its last bit arrives. The old contents need not be erased first.
- R7: Erase (opcode 11) sets the addressed word or byte to all ones at its last address bit. Erase all (opcode 00, top address bits 10) sets the whole array to ones.
- R8: Write all (opcode 00, top address bits 01) stores the following data word in every location. In 8-bit mode both bytes of each word receive the byte.
- R9: A programming command received while programming is disabled changes no memory and starts no busy cycle.
- R10: A programming cycle lasts PROG_CYCLES clocks. Status is shown only if chip select rises while busy and had been low for at least MIN_CS_LOW clocks. In that case dout_en goes high with dout 0 while busy, and dout goes to 1 once ready, until chip select falls.
- R11: dout_en is low in the cycle after chip select is sampled low, and is low whenever no read or status phase is active.
- R12: Dropping chip select before a command is complete abandons it and leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples all serial pins |
| rst_n | input | 1 | Active-low reset (power-up) |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock, acted on at its rising edge |
| di | input | 1 | Serial data in |
| org | input | 1 | Organization: 1 selects 16-bit words, 0 selects 8-bit words |
| dout | output | 1 | Serial data out / ready-busy status |
| dout_en | output | 1 | Drive enable of dout; low means high impedance |

## Verification
The assertions assume that sk, di and org change only while the system clock samples them as steady. They also assume that each sk level lasts at least one system clock, and that org is constant from the start bit until chip select falls. The bench changes every pin on the falling edge of the system clock and holds each shift-clock level for two clocks. It changes org only while chip select is low. It also waits out every programming cycle before opening a new command, so the start-bit lockout during busy is never exercised against the status checks.

// File: rtl/eeprom3w_pkg.sv
package eeprom3w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_HOLD
  } fsm_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_DIS   = 2'b00;
  localparam logic [1:0] SUB_WRALL = 2'b01;
  localparam logic [1:0] SUB_ERALL = 2'b10;
  localparam logic [1:0] SUB_EN    = 2'b11;

  // top two bits of an address field that is alen bits long
  function automatic logic [1:0] sub_cmd(input logic [15:0] a, input int alen);
    return a[alen-1 -: 2];
  endfunction

  // upper-half selection in byte mode
  function automatic logic byte_is_hi(input logic [15:0] a);
    return a[0];
  endfunction

endpackage

// File: rtl/eeprom3w_array.sv
module eeprom3w_array #(
  parameter int NWORDS = 64,
  parameter int DW     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_all,
  input  logic [$clog2(NWORDS)-1:0] wr_idx,
  input  logic [1:0]                wr_be,
  input  logic [DW-1:0]             wr_data,
  input  logic [$clog2(NWORDS)-1:0] rd_idx,
  output logic [DW-1:0]             rd_data
);
  localparam int IW = $clog2(NWORDS);
  localparam int HW = DW / 2;

  logic [NWORDS*DW-1:0] mem_flat;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    logic          hit;
    assign hit = wr_en && (wr_all || wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '1;
      end else if (hit) begin
        if (wr_be[0]) word_q[HW-1:0]  <= wr_data[HW-1:0];
        if (wr_be[1]) word_q[DW-1:HW] <= wr_data[DW-1:HW];
      end
    end
    assign mem_flat[g*DW +: DW] = word_q;
  end

  assign rd_data = mem_flat[rd_idx*DW +: DW];

  // R12: no strobe, no change anywhere in the array
  a_r12_array_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_flat));

endmodule

// File: rtl/eeprom3w_prog_timer.sv
module eeprom3w_prog_timer #(
  parameter int CYCLES = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(CYCLES + 1);

  logic [TW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (start)           remain_q <= TW'(CYCLES);
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign busy = (remain_q != '0);

  // R10: a new cycle is never launched on top of a running one
  a_r10_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R10: busy appears only as the result of a start request
  a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/eeprom3w.sv
module eeprom3w
  import eeprom3w_pkg::*;
#(
  parameter int AW8         = 7,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 60,
  parameter int MIN_CS_LOW  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic dout,
  output logic dout_en
);
  localparam int AW16   = AW8 - 1;
  localparam int NWORDS = 1 << AW16;
  localparam int HW     = DW / 2;
  localparam int CW     = $clog2(DW + 1);
  localparam int LW     = $clog2(MIN_CS_LOW + 1);

  fsm_t            state_q;
  logic            cs_q, sk_q, sk_rise, cs_rise;
  logic [CW-1:0]   cnt_q, alen, wlen;
  logic [1:0]      op_q;
  logic [AW8-1:0]  addr_q, addr_nxt, a_sel;
  logic [DW-1:0]   data_q, data_nxt, out_sr;
  logic [LW-1:0]   cs_low_q;
  logic            wen_q, status_q, busy;
  logic            last_addr, last_data;
  logic [1:0]      sub;
  logic            hi_sel;
  logic [AW16-1:0] word_idx;
  logic [DW-1:0]   rd_word;
  logic [HW-1:0]   rd_byte;
  logic            prog_req, prog_start, prog_all;
  logic [1:0]      prog_be;
  logic [DW-1:0]   prog_data;

  assign sk_rise  = cs && sk && !sk_q;
  assign cs_rise  = cs && !cs_q;
  assign alen     = org ? CW'(AW16) : CW'(AW8);
  assign wlen     = org ? CW'(DW)   : CW'(HW);
  assign addr_nxt = {addr_q[AW8-2:0], di};
  assign data_nxt = {data_q[DW-2:0], di};
  assign a_sel    = (state_q == ST_ADDR) ? addr_nxt : addr_q;
  assign sub      = sub_cmd(16'(a_sel), int'(alen));
  assign hi_sel   = byte_is_hi(16'(a_sel));
  assign word_idx = org ? a_sel[AW16-1:0] : a_sel[AW8-1:1];
  assign rd_byte  = hi_sel ? rd_word[DW-1:HW] : rd_word[HW-1:0];

  assign last_addr = sk_rise && state_q == ST_ADDR && cnt_q == alen - 1'b1;
  assign last_data = sk_rise && state_q == ST_DATA && cnt_q == wlen - 1'b1;

  // programming request, decided on the bit that completes a command
  always_comb begin
    prog_req  = 1'b0;
    prog_all  = 1'b0;
    prog_data = '1;
    prog_be   = org ? 2'b11 : (hi_sel ? 2'b10 : 2'b01);
    if (last_addr) begin
      if (op_q == OP_ERASE) prog_req = 1'b1;
      if (op_q == OP_EXT && sub == SUB_ERALL) begin
        prog_req = 1'b1;
        prog_all = 1'b1;
        prog_be  = 2'b11;
      end
    end
    if (last_data) begin
      prog_data = org ? data_nxt : {data_nxt[HW-1:0], data_nxt[HW-1:0]};
      if (op_q == OP_WRITE) prog_req = 1'b1;
      if (op_q == OP_EXT) begin
        prog_req = 1'b1;
        prog_all = 1'b1;
        prog_be  = 2'b11;
      end
    end
  end

  assign prog_start = prog_req && wen_q;

  eeprom3w_array #(.NWORDS(NWORDS), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(prog_start), .wr_all(prog_all), .wr_idx(word_idx),
    .wr_be(prog_be), .wr_data(prog_data),
    .rd_idx(word_idx), .rd_data(rd_word)
  );

  eeprom3w_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cs_q     <= 1'b0;
      sk_q     <= 1'b0;
      cnt_q    <= '0;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      out_sr   <= '0;
      cs_low_q <= '0;
      wen_q    <= 1'b0;
      status_q <= 1'b0;
      dout     <= 1'b0;
      dout_en  <= 1'b0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
      if (!cs) begin
        if (cs_low_q != LW'(MIN_CS_LOW)) cs_low_q <= cs_low_q + 1'b1;
        state_q  <= ST_IDLE;
        cnt_q    <= '0;
        status_q <= 1'b0;
        dout_en  <= 1'b0;
      end else begin
        cs_low_q <= '0;
        if (cs_rise && busy && cs_low_q >= LW'(MIN_CS_LOW)) begin
          status_q <= 1'b1;
          dout_en  <= 1'b1;
          dout     <= 1'b0;
        end else if (status_q) begin
          dout <= !busy;
        end
        if (sk_rise) begin
          unique case (state_q)
            ST_IDLE: if (di && !busy) begin
              state_q  <= ST_OPC;
              cnt_q    <= '0;
              status_q <= 1'b0;
              dout_en  <= 1'b0;
            end
            ST_OPC: begin
              op_q <= {op_q[0], di};
              if (cnt_q == CW'(1)) begin
                state_q <= ST_ADDR;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            ST_ADDR: begin
              addr_q <= addr_nxt;
              cnt_q  <= cnt_q + 1'b1;
              if (last_addr) begin
                cnt_q   <= '0;
                state_q <= ST_HOLD;
                unique case (op_q)
                  OP_READ: begin
                    out_sr  <= org ? rd_word : {rd_byte, {HW{1'b0}}};
                    dout    <= 1'b0;
                    dout_en <= 1'b1;
                    state_q <= ST_READ;
                  end
                  OP_WRITE: state_q <= ST_DATA;
                  OP_ERASE: state_q <= ST_HOLD;
                  default: begin
                    if (sub == SUB_EN)    wen_q   <= 1'b1;
                    if (sub == SUB_DIS)   wen_q   <= 1'b0;
                    if (sub == SUB_WRALL) state_q <= ST_DATA;
                  end
                endcase
              end
            end
            ST_DATA: begin
              data_q <= data_nxt;
              cnt_q  <= cnt_q + 1'b1;
              if (last_data) state_q <= ST_HOLD;
            end
            ST_READ: begin
              if (cnt_q == wlen) begin
                dout_en <= 1'b0;
                state_q <= ST_HOLD;
              end else begin
                dout   <= out_sr[DW-1];
                out_sr <= {out_sr[DW-2:0], 1'b0};
                cnt_q  <= cnt_q + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R11: chip select low releases the output on the next cycle
  a_r11_release_on_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !dout_en);
  // R9: a busy cycle is only ever entered with programming enabled
  a_r9_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q));
  // R10: status shows 0 while the timer is running
  a_r10_status_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && cs && busy) |=> !dout);
  // R10: status shows 1 once the timer has expired
  a_r10_status_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && cs && !busy) |=> dout);
  // R2: the first driven bit of a read is the zero dummy bit
  a_r2_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dout_en) && state_q == ST_READ) |-> !dout);

endmodule

// File: tb/eeprom3w_bench.sv
module eeprom3w_bench;
  localparam int PROG = 60;
  localparam int CSL  = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic dout, dout_en;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  eeprom3w #(.PROG_CYCLES(PROG), .MIN_CS_LOW(CSL)) u_eeprom3w (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .dout(dout), .dout_en(dout_en)
  );

  always #10 clk = ~clk;

  // {org, address, data}
  localparam logic [23:0] VEC [6] = '{
    {1'b1, 7'd0,   16'hA55A},
    {1'b1, 7'd63,  16'h0001},
    {1'b1, 7'd17,  16'h8000},
    {1'b0, 7'd0,   16'h003C},
    {1'b0, 7'd1,   16'h00C3},
    {1'b0, 7'd127, 16'h007E}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b, output logic o, output logic e);
    di = b;
    tick(2);
    sk = 1'b1;
    tick(2);
    o = dout;
    e = dout_en;
    sk = 1'b0;
  endtask

  function automatic int alen();
    return org ? 6 : 7;
  endfunction

  function automatic int wlen();
    return org ? 16 : 8;
  endfunction

  function automatic logic [6:0] ext_addr(input logic [1:0] s);
    return org ? {1'b0, s, 4'b0} : {s, 5'b0};
  endfunction

  task automatic send_head(input logic [1:0] op, input logic [6:0] a, input int pre,
                           output logic o, output logic e);
    cs = 1'b1;
    tick(2);
    for (int i = 0; i < pre; i++) sk_bit(1'b0, o, e);
    sk_bit(1'b1, o, e);
    sk_bit(op[1], o, e);
    sk_bit(op[0], o, e);
    for (int i = alen() - 1; i >= 0; i--) sk_bit(a[i], o, e);
  endtask

  task automatic send_data(input logic [15:0] d, input int n);
    logic o, e;
    for (int i = n - 1; i >= 0; i--) sk_bit(d[i], o, e);
  endtask

  task automatic prog(input logic [1:0] op, input logic [6:0] a, input logic [15:0] d, input bit with_data);
    logic o, e;
    send_head(op, a, 0, o, e);
    if (with_data) send_data(d, wlen());
    cs = 1'b0;
    tick(PROG + 10);
  endtask

  task automatic do_read(input logic [6:0] a, input int pre, input string tag, input logic [15:0] exp);
    logic o, e;
    logic [15:0] v;
    v = '0;
    send_head(2'b10, a, pre, o, e);
    chk(e === 1'b1 && o === 1'b0, {tag, " R2 dummy bit"}, {14'b0, e, o}, 16'h0002);
    for (int i = 0; i < wlen(); i++) begin
      sk_bit(1'b0, o, e);
      v = {v[14:0], o};
    end
    chk(v === exp, tag, v, exp);
    sk_bit(1'b0, o, e);
    chk(e === 1'b0, {tag, " R2 release after last bit"}, {15'b0, e}, 16'h0000);
    cs = 1'b0;
    tick(3);
  endtask

  task automatic status_probe(input int low, input logic exp_en, input string tag);
    cs = 1'b0;
    tick(low);
    cs = 1'b1;
    tick(3);
    chk(dout_en === exp_en, tag, {15'b0, dout_en}, {15'b0, exp_en});
  endtask

  initial begin
    tick(150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic o, e;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R4 R11: output released and array erased after reset
    chk(dout_en === 1'b0, "R4 R11 reset output released", {15'b0, dout_en}, 16'h0000);
    org = 1'b1;
    do_read(7'd0, 0, "R4 R5 reset contents, read while disabled", 16'hFFFF);

    // R9: write while disabled starts no busy cycle and stores nothing
    send_head(2'b01, 7'd3, 0, o, e);
    send_data(16'h0000, 16);
    status_probe(8, 1'b0, "R9 no busy cycle while disabled");
    cs = 1'b0;
    tick(PROG + 10);
    do_read(7'd3, 0, "R9 disabled write ignored", 16'hFFFF);

    // R5: enable programming
    prog(2'b00, ext_addr(2'b11), 16'h0, 1'b0);

    // R6 R3 R1: table of writes and read-backs in both organizations
    for (int k = 0; k < 6; k++) begin
      org = VEC[k][23];
      tick(2);
      prog(2'b01, VEC[k][22:16], VEC[k][15:0], 1'b1);
      do_read(VEC[k][22:16], 0, "R6 R3 table write/read",
              org ? VEC[k][15:0] : {8'h00, VEC[k][7:0]});
    end

    // R3: byte 1 is the upper half of word 0
    org = 1'b1;
    tick(2);
    do_read(7'd0, 0, "R3 byte placement in word", 16'hC33C);

    // R10: status polling during a write
    send_head(2'b01, 7'd9, 0, o, e);
    send_data(16'hBEEF, 16);
    cs = 1'b0;
    tick(8);
    cs = 1'b1;
    tick(3);
    chk(dout_en === 1'b1 && dout === 1'b0, "R10 busy status", {14'b0, dout_en, dout}, 16'h0002);
    tick(PROG + 5);
    chk(dout_en === 1'b1 && dout === 1'b1, "R10 ready status", {14'b0, dout_en, dout}, 16'h0003);
    cs = 1'b0;
    tick(3);
    chk(dout_en === 1'b0, "R11 released after status", {15'b0, dout_en}, 16'h0000);
    do_read(7'd9, 0, "R6 written under status", 16'hBEEF);

    // R10 R7: chip select raised after the cycle ended shows nothing
    send_head(2'b11, 7'd9, 0, o, e);
    status_probe(PROG + 10, 1'b0, "R10 no status after cycle end");
    cs = 1'b0;
    tick(3);
    do_read(7'd9, 0, "R7 erase word", 16'hFFFF);

    // R10: too short a low time shows no status
    send_head(2'b01, 7'd10, 0, o, e);
    send_data(16'h1111, 16);
    status_probe(2, 1'b0, "R10 short cs low no status");
    cs = 1'b0;
    tick(PROG + 10);
    do_read(7'd10, 0, "R6 write after short probe", 16'h1111);

    // R12: abort in the middle of the data field
    send_head(2'b01, 7'd10, 0, o, e);
    send_data(16'h00FF, 8);
    cs = 1'b0;
    tick(PROG + 10);
    do_read(7'd10, 0, "R12 aborted write", 16'h1111);

    // R1: leading zeros before the start bit
    do_read(7'd10, 3, "R1 leading zeros skipped", 16'h1111);

    // R8: write all in both organizations
    prog(2'b00, ext_addr(2'b01), 16'h2468, 1'b1);
    do_read(7'd5, 0, "R8 write all x16 low", 16'h2468);
    do_read(7'd63, 0, "R8 write all x16 top", 16'h2468);
    org = 1'b0;
    tick(2);
    prog(2'b00, ext_addr(2'b01), 16'h00A5, 1'b1);
    org = 1'b1;
    tick(2);
    do_read(7'd7, 0, "R8 write all x8 both bytes", 16'hA5A5);

    // R7: erase all
    prog(2'b00, ext_addr(2'b10), 16'h0, 1'b0);
    do_read(7'd0, 0, "R7 erase all word 0", 16'hFFFF);
    do_read(7'd40, 0, "R7 erase all word 40", 16'hFFFF);

    // R5 R9: disable, then a write is refused
    prog(2'b00, ext_addr(2'b00), 16'h0, 1'b0);
    prog(2'b01, 7'd2, 16'h0000, 1'b1);
    do_read(7'd2, 0, "R5 R9 write refused after disable", 16'hFFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule